// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block holds recently used page translations so that an address translation that finds its entry here skips the multi-level table walk. Storage is 16 sets of 4 ways. A 20-bit virtual page number selects a set with its low 4 bits and is compared against a 16-bit tag taken from its upper 16 bits. Each way holds a valid bit, a kind flag (1 for a cached directory entry, 0 for a cached table entry), the tag and the 32-bit entry itself.

A lookup presents a page number, the kind of entry wanted and the 12-bit page offset. One cycle later the block reports a hit or a miss, the cached entry and the physical address. On a miss it reports which walks the requester must perform. After a walk, the requester writes the entry through the fill port. A fill takes a way that already holds the same tag and kind, or else the lowest free way, or else the way named by a 3-bit pseudo-LRU tree kept for each set. Software keeps the cache coherent with a single-page invalidate, and a task-switch flush drops every entry not marked global.

Top module: `xlat_cache`

## Requirements
- R1: After reset every way is invalid, `rs_valid` is 0, and any lookup misses.
- R2: A lookup with `lk_valid` high gives `rs_valid` high in the next cycle only. `rs_hit` is 1 when a valid way in set `lk_vpn[3:0]` has tag `lk_vpn[19:4]` and a kind equal to `lk_kind`, and then `rs_entry` is that way's stored entry.
- R3: On a hit `rs_paddr` equals entry bits 31:12 followed by `lk_offset`.
- R4: A way whose tag matches but whose kind differs from `lk_kind` does not give a hit.
- R5: On a hit both walk flags are 0. On a table-kind miss (`lk_kind`=0), `rs_need_leaf` is 1 and `rs_need_dir` is 1 unless a valid directory-kind way with the same tag is in the set. On a directory-kind miss, `rs_need_dir` is 1 and `rs_need_leaf` is 0.
- R6: Page numbers that share a tag but differ in set index, or share an index but differ in tag, never hit on each other's entries.
- R7: A fill overwrites the valid way that holds the same tag and kind. Otherwise it takes the lowest-numbered invalid way, and when all four ways are valid it takes the pseudo-LRU victim.
- R8: Each set keeps three tree bits, all 0 at reset. Bit 0 picks a pair (0: ways 0-1, 1: ways 2-3), bit 1 picks within the low pair and bit 2 within the high pair. Every hit and every fill points the bits on its way's path away from that way.
- R9: An invalidate clears, in the cycle it is presented, every way in set `iv_vpn[3:0]` with tag `iv_vpn[19:4]`, of either kind, even when the entry's global bit is set.
- R10: A flush clears every way whose entry bit 8 (global) is 0 and leaves ways with bit 8 set valid.
- R11: When a fill and a lookup reach the same set in the same cycle, the lookup result reflects the fill. The fill alone updates that set's tree bits.
- R12: In one cycle the fill is applied first, and then the invalidate and the flush act on the result. A non-global fill paired with a flush, or a fill paired with an invalidate of its own page, leaves no valid entry.
- R13: No more than one way in a set ever matches a given tag and kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_kind | input | 1 | Requested entry kind: 1 directory, 0 table |
| lk_offset | input | 12 | Page offset for the physical address |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 20 | Fill virtual page number |
| fl_kind | input | 1 | Kind of the filled entry |
| fl_entry | input | 32 | Entry to store |
| iv_valid | input | 1 | Single-page invalidate request |
| iv_vpn | input | 20 | Page number to invalidate |
| sw_flush | input | 1 | Task-switch flush of non-global entries |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Lookup hit |
| rs_entry | output | 32 | Cached entry on a hit, else 0 |
| rs_paddr | output | 32 | Physical address on a hit, else 0 |
| rs_need_leaf | output | 1 | Miss: the table entry must be fetched |
| rs_need_dir | output | 1 | Miss: the directory entry must be fetched |

## Verification
Every cycle, assertions check the one-cycle result timing and the page offset carried into the physical address. They also check that the walk flags agree with hit or miss, that a set never holds two matching ways, and that each way follows the rules for invalidate and flush: an invalidated way is gone, a global way survives a flush, and a local way does not. Directed scenarios cover the rest, because these depend on history: which way a fill replaces after a given sequence of hits, that a refill does not duplicate an entry, how a fill and a lookup interact in one set in the same cycle, and the ordering of fill against invalidate and flush.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VPN_W      = 20;
    localparam int SET_BITS   = 4;
    localparam int WAYS       = 4;
    localparam int ENTRY_W    = 32;
    localparam int OFF_W      = 12;
    localparam int GLOBAL_BIT = 8;

    localparam int SETS   = 1 << SET_BITS;
    localparam int TAG_W  = VPN_W - SET_BITS;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;
    localparam int PA_W   = ENTRY_W;

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [SET_BITS-1:0] idx_t;
    typedef logic [WAY_W-1:0]    way_idx_t;
    typedef logic [TREE_W-1:0]   tree_t;

    typedef struct packed {
        logic               valid;
        logic               is_dir;
        tag_t               tag;
        logic [ENTRY_W-1:0] entry;
    } way_t;

    typedef way_t [WAYS-1:0] set_t;

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic               need_leaf;
        logic               need_dir;
        logic [ENTRY_W-1:0] entry;
        logic [PA_W-1:0]    paddr;
    } result_t;

    // Point the tree bits on the path to way w away from it.
    function automatic tree_t plru_touch(input tree_t t, input way_idx_t w);
        tree_t n;
        n    = t;
        n[0] = ~w[1];
        if (!w[1]) n[1] = ~w[0];
        else       n[2] = ~w[0];
        return n;
    endfunction
endpackage

// File: rtl/xlat_probe.sv
module xlat_probe
    import xlat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  set_t     ways,
    input  tag_t     tag,
    input  logic     kind,
    output logic     hit,
    output way_idx_t way
);
    logic [WAYS-1:0] match;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_cmp
            assign match[g] = ways[g].valid && (ways[g].tag == tag) && (ways[g].is_dir == kind);
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                way = way_idx_t'(i);
            end
        end
    end

    // R13: a set never holds two ways with the same tag and kind
    p_single_match_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
(
    input  set_t     ways,
    input  logic     found,
    input  way_idx_t found_way,
    input  tree_t    tree,
    output way_idx_t pick
);
    logic     have_free;
    way_idx_t free_way;
    way_idx_t lru_way;

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!ways[i].valid) begin
                have_free = 1'b1;
                free_way  = way_idx_t'(i);
            end
        end
    end

    assign lru_way = tree[0] ? {1'b1, tree[2]} : {1'b0, tree[1]};

    always_comb begin
        if (found)          pick = found_way;
        else if (have_free) pick = free_way;
        else                pick = lru_way;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic               lk_kind,
    input  logic [OFF_W-1:0]   lk_offset,
    input  logic               fl_valid,
    input  logic [VPN_W-1:0]   fl_vpn,
    input  logic               fl_kind,
    input  logic [ENTRY_W-1:0] fl_entry,
    input  logic               iv_valid,
    input  logic [VPN_W-1:0]   iv_vpn,
    input  logic               sw_flush,
    output logic               rs_valid,
    output logic               rs_hit,
    output logic [ENTRY_W-1:0] rs_entry,
    output logic [PA_W-1:0]    rs_paddr,
    output logic               rs_need_leaf,
    output logic               rs_need_dir
);
    set_t    ways_q [SETS];
    set_t    ways_d [SETS];
    tree_t   tree_q [SETS];
    tree_t   tree_d [SETS];
    result_t res_q, res_d;

    idx_t lk_idx, fl_idx, iv_idx;
    tag_t lk_tag, fl_tag, iv_tag;

    assign lk_idx = lk_vpn[SET_BITS-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_BITS];
    assign fl_idx = fl_vpn[SET_BITS-1:0];
    assign fl_tag = fl_vpn[VPN_W-1:SET_BITS];
    assign iv_idx = iv_vpn[SET_BITS-1:0];
    assign iv_tag = iv_vpn[VPN_W-1:SET_BITS];

    // Fill placement: look for an existing copy, then pick a way.
    logic     fl_found;
    way_idx_t fl_found_way;
    way_idx_t fill_way;

    xlat_probe u_fill_probe (
        .clk   (clk),
        .rst_n (rst_n),
        .ways  (ways_q[fl_idx]),
        .tag   (fl_tag),
        .kind  (fl_kind),
        .hit   (fl_found),
        .way   (fl_found_way)
    );

    xlat_victim u_victim (
        .ways      (ways_q[fl_idx]),
        .found     (fl_found),
        .found_way (fl_found_way),
        .tree      (tree_q[fl_idx]),
        .pick      (fill_way)
    );

    // Array next state: fill first, then invalidate and flush on top.
    always_comb begin
        ways_d = ways_q;
        if (fl_valid) begin
            ways_d[fl_idx][fill_way].valid  = 1'b1;
            ways_d[fl_idx][fill_way].is_dir = fl_kind;
            ways_d[fl_idx][fill_way].tag    = fl_tag;
            ways_d[fl_idx][fill_way].entry  = fl_entry;
        end
        if (iv_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (ways_d[iv_idx][w].tag == iv_tag) ways_d[iv_idx][w].valid = 1'b0;
            end
        end
        if (sw_flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (!ways_d[s][w].entry[GLOBAL_BIT]) ways_d[s][w].valid = 1'b0;
                end
            end
        end
    end

    // Lookup sees the contents after this cycle's writes.
    logic     lk_hit;
    way_idx_t lk_way;
    logic     lk_dir_seen;

    xlat_probe u_look_probe (
        .clk   (clk),
        .rst_n (rst_n),
        .ways  (ways_d[lk_idx]),
        .tag   (lk_tag),
        .kind  (lk_kind),
        .hit   (lk_hit),
        .way   (lk_way)
    );

    always_comb begin
        lk_dir_seen = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (ways_d[lk_idx][w].valid && ways_d[lk_idx][w].is_dir &&
                (ways_d[lk_idx][w].tag == lk_tag))
                lk_dir_seen = 1'b1;
        end
    end

    // Replacement state and lookup result.
    always_comb begin
        logic [ENTRY_W-1:0] hit_entry;
        tree_d    = tree_q;
        hit_entry = ways_d[lk_idx][lk_way].entry;
        if (lk_valid && lk_hit && !(fl_valid && (fl_idx == lk_idx)))
            tree_d[lk_idx] = plru_touch(tree_q[lk_idx], lk_way);
        if (fl_valid)
            tree_d[fl_idx] = plru_touch(tree_q[fl_idx], fill_way);

        res_d = '0;
        if (lk_valid) begin
            res_d.valid = 1'b1;
            if (lk_hit) begin
                res_d.hit   = 1'b1;
                res_d.entry = hit_entry;
                res_d.paddr = {hit_entry[ENTRY_W-1:OFF_W], lk_offset};
            end else begin
                res_d.need_leaf = !lk_kind;
                res_d.need_dir  = lk_kind || !lk_dir_seen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ways_q[s] <= '0;
                tree_q[s] <= '0;
            end
            res_q <= '0;
        end else begin
            ways_q <= ways_d;
            tree_q <= tree_d;
            res_q  <= res_d;
        end
    end

    assign rs_valid     = res_q.valid;
    assign rs_hit       = res_q.hit;
    assign rs_entry     = res_q.entry;
    assign rs_paddr     = res_q.paddr;
    assign rs_need_leaf = res_q.need_leaf;
    assign rs_need_dir  = res_q.need_dir;

    // R2: a result appears exactly one cycle after each lookup
    p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    p_result_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    // R3: the page offset passes straight into the physical address
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rs_hit || (rs_paddr[OFF_W-1:0] == $past(lk_offset))));

    // R5: walk flags agree with hit or miss
    p_hit_no_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_hit) |-> (!rs_need_leaf && !rs_need_dir));
    p_miss_walks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_need_leaf || rs_need_dir));

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set_chk
            for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
                // R9: an invalidated way is gone next cycle
                p_inval_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    (iv_valid && !fl_valid && (iv_idx == idx_t'(s)) &&
                     ways_q[s][w].valid && (ways_q[s][w].tag == iv_tag))
                    |=> !ways_q[s][w].valid);
                // R10: a flush keeps global ways
                p_flush_keeps_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
                    (sw_flush && !iv_valid && !fl_valid && ways_q[s][w].valid &&
                     ways_q[s][w].entry[GLOBAL_BIT])
                    |=> ways_q[s][w].valid);
                // R10: a flush drops local ways
                p_flush_drops_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
                    (sw_flush && !fl_valid && !ways_q[s][w].entry[GLOBAL_BIT])
                    |=> !ways_q[s][w].valid);
            end
        end
    endgenerate
endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_kind = 1'b0;
    logic [11:0] lk_offset = '0;
    logic        fl_valid = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic        fl_kind = 1'b0;
    logic [31:0] fl_entry = '0;
    logic        iv_valid = 1'b0;
    logic [19:0] iv_vpn = '0;
    logic        sw_flush = 1'b0;
    logic        rs_valid, rs_hit, rs_need_leaf, rs_need_dir;
    logic [31:0] rs_entry, rs_paddr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xlat_cache dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind(lk_kind), .lk_offset(lk_offset),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_kind(fl_kind), .fl_entry(fl_entry),
        .iv_valid(iv_valid), .iv_vpn(iv_vpn), .sw_flush(sw_flush),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_entry(rs_entry), .rs_paddr(rs_paddr),
        .rs_need_leaf(rs_need_leaf), .rs_need_dir(rs_need_dir)
    );

    function automatic logic [31:0] mk(input logic [19:0] ppn, input logic glob);
        return {ppn, 3'b000, glob, 8'h27};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic kind, input logic [31:0] ent);
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = vpn; fl_kind = kind; fl_entry = ent;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [19:0] vpn, input logic kind,
                        input logic [11:0] off, input logic exp_hit, input logic [31:0] exp_ent,
                        input logic exp_leaf, input logic exp_dir);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = vpn; lk_kind = kind; lk_offset = off;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " rs_valid"}, 32'(rs_valid), 32'd1);
        chk({req, " hit"}, 32'(rs_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk({req, " entry"}, rs_entry, exp_ent);
            chk({req, " paddr"}, rs_paddr, {exp_ent[31:12], off});
        end
        chk({req, " need_leaf"}, 32'(rs_need_leaf), 32'(exp_leaf));
        chk({req, " need_dir"}, 32'(rs_need_dir), 32'(exp_dir));
    endtask

    task automatic t_reset;
        chk("R1 idle result", 32'(rs_valid), 32'd0);
        look("R1 empty miss", 20'h12345, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
        @(negedge clk);
        chk("R2 no result without lookup", 32'(rs_valid), 32'd0);
    endtask

    task automatic t_basic;
        fill(20'hABCD1, 1'b0, mk(20'h55555, 1'b0));
        look("R2 R3 basic hit", 20'hABCD1, 1'b0, 12'h123, 1'b1, mk(20'h55555, 1'b0), 1'b0, 1'b0);
    endtask

    task automatic t_kind;
        look("R4 R5 dir-kind miss", 20'hABCD1, 1'b1, 12'h0, 1'b0, '0, 1'b0, 1'b1);
        fill(20'h77772, 1'b1, mk(20'h01234, 1'b0));
        look("R4 R5 table miss dir cached", 20'h77772, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b0);
        look("R4 dir hit", 20'h77772, 1'b1, 12'hFFF, 1'b1, mk(20'h01234, 1'b0), 1'b0, 1'b0);
    endtask

    task automatic t_index;
        fill(20'h00013, 1'b0, mk(20'h00AAA, 1'b0));
        look("R6 other set", 20'h00014, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
        look("R6 other tag", 20'h00023, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
        look("R6 own entry", 20'h00013, 1'b0, 12'h001, 1'b1, mk(20'h00AAA, 1'b0), 1'b0, 1'b0);
    endtask

    task automatic t_refill;
        fill(20'hABCD1, 1'b0, mk(20'h66666, 1'b0));
        fill(20'h11111, 1'b0, mk(20'h00001, 1'b0));
        fill(20'h22221, 1'b0, mk(20'h00002, 1'b0));
        fill(20'h33331, 1'b0, mk(20'h00003, 1'b0));
        look("R7 R13 refilled", 20'hABCD1, 1'b0, 12'h0, 1'b1, mk(20'h66666, 1'b0), 1'b0, 1'b0);
        look("R13 way b", 20'h11111, 1'b0, 12'h0, 1'b1, mk(20'h00001, 1'b0), 1'b0, 1'b0);
        look("R13 way c", 20'h22221, 1'b0, 12'h0, 1'b1, mk(20'h00002, 1'b0), 1'b0, 1'b0);
        look("R13 way d", 20'h33331, 1'b0, 12'h0, 1'b1, mk(20'h00003, 1'b0), 1'b0, 1'b0);
    endtask

    task automatic t_plru;
        // ways 0..3 filled in order; tree then points at way 0; hit on way 0 moves it to way 2
        fill(20'h00A05, 1'b0, mk(20'h000A0, 1'b0));
        fill(20'h00B05, 1'b0, mk(20'h000B0, 1'b0));
        fill(20'h00C05, 1'b0, mk(20'h000C0, 1'b0));
        fill(20'h00D05, 1'b0, mk(20'h000D0, 1'b0));
        look("R8 touch way0", 20'h00A05, 1'b0, 12'h0, 1'b1, mk(20'h000A0, 1'b0), 1'b0, 1'b0);
        fill(20'h00E05, 1'b0, mk(20'h000E0, 1'b0));
        look("R7 R8 victim way2 gone", 20'h00C05, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
        look("R8 keep a", 20'h00A05, 1'b0, 12'h0, 1'b1, mk(20'h000A0, 1'b0), 1'b0, 1'b0);
        look("R8 keep b", 20'h00B05, 1'b0, 12'h0, 1'b1, mk(20'h000B0, 1'b0), 1'b0, 1'b0);
        look("R8 keep d", 20'h00D05, 1'b0, 12'h0, 1'b1, mk(20'h000D0, 1'b0), 1'b0, 1'b0);
        look("R7 new e", 20'h00E05, 1'b0, 12'h0, 1'b1, mk(20'h000E0, 1'b0), 1'b0, 1'b0);
    endtask

    task automatic t_inval;
        fill(20'h44446, 1'b0, mk(20'h0F0F0, 1'b1));
        fill(20'h44446, 1'b1, mk(20'h0E0E0, 1'b1));
        fill(20'h55556, 1'b0, mk(20'h0D0D0, 1'b0));
        @(negedge clk);
        iv_valid = 1'b1; iv_vpn = 20'h44446;
        @(negedge clk);
        iv_valid = 1'b0;
        look("R9 global table gone", 20'h44446, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
        look("R9 dir gone", 20'h44446, 1'b1, 12'h0, 1'b0, '0, 1'b0, 1'b1);
        look("R9 neighbour kept", 20'h55556, 1'b0, 12'h0, 1'b1, mk(20'h0D0D0, 1'b0), 1'b0, 1'b0);
    endtask

    task automatic t_flush;
        fill(20'h10007, 1'b0, mk(20'h0ABCD, 1'b1));
        fill(20'h20007, 1'b0, mk(20'h0DCBA, 1'b0));
        @(negedge clk);
        sw_flush = 1'b1;
        @(negedge clk);
        sw_flush = 1'b0;
        look("R10 global kept", 20'h10007, 1'b0, 12'h0, 1'b1, mk(20'h0ABCD, 1'b1), 1'b0, 1'b0);
        look("R10 local dropped", 20'h20007, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
        look("R10 older local dropped", 20'h00A05, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = 20'h99998; fl_kind = 1'b0; fl_entry = mk(20'h13579, 1'b0);
        lk_valid = 1'b1; lk_vpn = 20'h99998; lk_kind = 1'b0; lk_offset = 12'h456;
        @(negedge clk);
        fl_valid = 1'b0; lk_valid = 1'b0;
        chk("R11 hit on fill", 32'(rs_hit), 32'd1);
        chk("R11 entry", rs_entry, mk(20'h13579, 1'b0));
        chk("R11 paddr", rs_paddr, 32'h13579456);
    endtask

    task automatic t_order;
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = 20'h5555A; fl_kind = 1'b0; fl_entry = mk(20'h0AAAA, 1'b0);
        sw_flush = 1'b1;
        @(negedge clk);
        fl_valid = 1'b0; sw_flush = 1'b0;
        look("R12 fill then flush", 20'h5555A, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
        @(negedge clk);
        fl_valid = 1'b1; fl_vpn = 20'h6666B; fl_kind = 1'b0; fl_entry = mk(20'h0BBBB, 1'b1);
        iv_valid = 1'b1; iv_vpn = 20'h6666B;
        @(negedge clk);
        fl_valid = 1'b0; iv_valid = 1'b0;
        look("R12 fill then invalidate", 20'h6666B, 1'b0, 12'h0, 1'b0, '0, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_kind();
        t_index();
        t_refill();
        t_plru();
        t_inval();
        t_flush();
        t_same_cycle();
        t_order();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule